// File: doc/BRIEF.md
# Microcoded Two-Dice Game Controller

This block is the control unit of a two-dice pass-line game, built as a single-address microprogrammed sequencer. A 4-bit address register selects one word of a 16-word control store. Each word carries a qualifier select, a branch target and four Moore outputs. The outputs are the dice roll enable, the point-capture strobe, the win lamp and the lose lamp. When the selected qualifier is true, the address jumps to the branch target. When it is false, the address steps to the next word, and the step wraps modulo 16.

Around the sequencer sit a decoder that classifies the dice sum, a point register and an equality comparator. The dice counters are outside the block. While `roll_en` is high they run, and they present their total on `dice_sum`, a value from 2 to 12.

The player holds `roll_btn` to roll and releases it to read the dice. The first sum decides an immediate win, an immediate loss, or a point. Later rolls repeat until the sum matches the point or comes up seven. The result lamp stays lit until `clear_btn` is pressed.

Top module: `dice_microseq`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to its idle word (address 0). In idle, `roll_en`, `win_lamp` and `lose_lamp` are all low, and the controller waits for `roll_btn`.
- R2: A press of `roll_btn` in idle, or in the waiting-for-next-roll word, raises `roll_en` from the following cycle. `roll_en` stays high for as long as the button is held.
- R3: When the button is released on the first roll and `dice_sum` is 7 or 11, `win_lamp` rises two cycles after the release is sampled.
- R4: When the button is released on the first roll and `dice_sum` is 2, 3 or 12, `lose_lamp` rises three cycles after the release is sampled.
- R5: Any other first sum is captured as the point on the edge that leaves the capture word (address 4). The controller then waits with all outputs low for the next press.
- R6: On a later roll, a sum equal to the stored point lights `win_lamp`.
- R7: On a later roll, a sum of 7 lights `lose_lamp`. Any other sum returns the controller to waiting, with all outputs low.
- R8: The win lamp (address 15) and the lose lamp (address 9) stay lit until `clear_btn` is sampled high. After a win, the next address is 0 by wrap-around. After a loss, the controller passes through one dark word (address 10) and then reaches address 0. `clear_btn` has no effect in any other word.
- R9: At most one of `roll_en`, `win_lamp` and `lose_lamp` is high in any cycle.
- R10: The point register changes only on the capture edge. Later non-matching rolls leave it unchanged, so a match against the original point still wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the idle word |
| roll_btn | input | 1 | Roll button, high while pressed |
| clear_btn | input | 1 | New-game button that clears a lit result lamp |
| dice_sum | input | SUM_W | Total of the two dice, 2 to 12 |
| roll_en | output | 1 | Enables the external dice counters |
| win_lamp | output | 1 | Win indicator |
| lose_lamp | output | 1 | Lose indicator |

## Verification
Every output is a Moore function of the address register. A wrong address therefore appears at the ports within one to three cycles: a lamp lights early or late, `roll_en` drops while the button is held, or the controller ignores a press. The point register is the exception, because its effect is delayed. A corrupted or reloaded point shows up only when a later roll should match and does not, possibly several rounds later. For this reason the bench plays a game with several non-matching rolls before the matching one.

// File: rtl/dice_mc_pkg.sv
package dice_mc_pkg;

    localparam int ADDR_W      = 4;
    localparam int TEST_W      = 3;
    localparam int NUM_QUAL    = 1 << TEST_W;
    localparam int STORE_DEPTH = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [TEST_W-1:0] {
        Q_BTN_UP    = 3'd0,
        Q_BTN_DOWN  = 3'd1,
        Q_NATURAL   = 3'd2,
        Q_CRAPS     = 3'd3,
        Q_MATCH     = 3'd4,
        Q_NOT_SEVEN = 3'd5,
        Q_CLEAR_UP  = 3'd6,
        Q_ALWAYS    = 3'd7
    } qual_e;

    typedef struct packed {
        qual_e test;
        addr_t target;
        logic  roll;
        logic  capture;
        logic  win;
        logic  lose;
    } uword_t;

    typedef struct packed {
        logic seven;
        logic natural;
        logic craps;
    } sum_class_t;

    typedef struct packed {
        logic       btn;
        logic       clr;
        logic       match;
        sum_class_t cls;
    } qual_in_t;

    localparam addr_t A_IDLE  = 4'd0;
    localparam addr_t A_ROLL1 = 4'd1;
    localparam addr_t A_NAT   = 4'd2;
    localparam addr_t A_CRAPS = 4'd3;
    localparam addr_t A_SAVE  = 4'd4;
    localparam addr_t A_WAIT  = 4'd5;
    localparam addr_t A_ROLLN = 4'd6;
    localparam addr_t A_MATCH = 4'd7;
    localparam addr_t A_SEVEN = 4'd8;
    localparam addr_t A_LOST  = 4'd9;
    localparam addr_t A_EXIT  = 4'd10;
    localparam addr_t A_WON   = 4'd15;

    function automatic uword_t mk(qual_e t, addr_t n, logic r, logic c, logic w, logic l);
        uword_t u;
        u.test    = t;
        u.target  = n;
        u.roll    = r;
        u.capture = c;
        u.win     = w;
        u.lose    = l;
        return u;
    endfunction

    function automatic uword_t ustore(addr_t a);
        case (a)
            A_IDLE:  return mk(Q_BTN_UP,    A_IDLE,  1'b0, 1'b0, 1'b0, 1'b0);
            A_ROLL1: return mk(Q_BTN_DOWN,  A_ROLL1, 1'b1, 1'b0, 1'b0, 1'b0);
            A_NAT:   return mk(Q_NATURAL,   A_WON,   1'b0, 1'b0, 1'b0, 1'b0);
            A_CRAPS: return mk(Q_CRAPS,     A_LOST,  1'b0, 1'b0, 1'b0, 1'b0);
            A_SAVE:  return mk(Q_ALWAYS,    A_WAIT,  1'b0, 1'b1, 1'b0, 1'b0);
            A_WAIT:  return mk(Q_BTN_UP,    A_WAIT,  1'b0, 1'b0, 1'b0, 1'b0);
            A_ROLLN: return mk(Q_BTN_DOWN,  A_ROLLN, 1'b1, 1'b0, 1'b0, 1'b0);
            A_MATCH: return mk(Q_MATCH,     A_WON,   1'b0, 1'b0, 1'b0, 1'b0);
            A_SEVEN: return mk(Q_NOT_SEVEN, A_WAIT,  1'b0, 1'b0, 1'b0, 1'b0);
            A_LOST:  return mk(Q_CLEAR_UP,  A_LOST,  1'b0, 1'b0, 1'b0, 1'b1);
            A_EXIT:  return mk(Q_ALWAYS,    A_IDLE,  1'b0, 1'b0, 1'b0, 1'b0);
            A_WON:   return mk(Q_CLEAR_UP,  A_WON,   1'b0, 1'b0, 1'b1, 1'b0);
            default: return mk(Q_ALWAYS,    A_IDLE,  1'b0, 1'b0, 1'b0, 1'b0);
        endcase
    endfunction

endpackage

// File: rtl/dice_sum_decode.sv
module dice_sum_decode
    import dice_mc_pkg::*;
#(
    parameter int SUM_W = 4
) (
    input  logic [SUM_W-1:0] sum,
    output sum_class_t       cls
);
    localparam logic [SUM_W-1:0] V2  = SUM_W'(2);
    localparam logic [SUM_W-1:0] V3  = SUM_W'(3);
    localparam logic [SUM_W-1:0] V7  = SUM_W'(7);
    localparam logic [SUM_W-1:0] V11 = SUM_W'(11);
    localparam logic [SUM_W-1:0] V12 = SUM_W'(12);

    always_comb begin
        cls.seven   = (sum == V7);
        cls.natural = (sum == V7) || (sum == V11);
        cls.craps   = (sum == V2) || (sum == V3) || (sum == V12);
    end
endmodule

// File: rtl/dice_point_unit.sv
module dice_point_unit #(
    parameter int SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SUM_W-1:0] sum,
    output logic [SUM_W-1:0] point,
    output logic             match
);
    always_ff @(posedge clk) begin
        if (rst) begin
            point <= '0;
        end else if (load) begin
            point <= sum;
        end
    end

    assign match = (sum == point);
endmodule

// File: rtl/dice_useq.sv
module dice_useq
    import dice_mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  qual_in_t qin,
    output addr_t    addr,
    output uword_t   word
);
    logic [NUM_QUAL-1:0] qv;
    logic                take;
    addr_t               nxt;

    always_comb begin
        word                 = ustore(addr);
        qv[int'(Q_BTN_UP)]    = ~qin.btn;
        qv[int'(Q_BTN_DOWN)]  = qin.btn;
        qv[int'(Q_NATURAL)]   = qin.cls.natural;
        qv[int'(Q_CRAPS)]     = qin.cls.craps;
        qv[int'(Q_MATCH)]     = qin.match;
        qv[int'(Q_NOT_SEVEN)] = ~qin.cls.seven;
        qv[int'(Q_CLEAR_UP)]  = ~qin.clr;
        qv[int'(Q_ALWAYS)]    = 1'b1;
        take                 = qv[int'(word.test)];
        nxt                  = take ? word.target : addr_t'(addr + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= A_IDLE;
        end else begin
            addr <= nxt;
        end
    end
endmodule

// File: rtl/dice_microseq.sv
module dice_microseq
    import dice_mc_pkg::*;
#(
    parameter int SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             roll_btn,
    input  logic             clear_btn,
    input  logic [SUM_W-1:0] dice_sum,
    output logic             roll_en,
    output logic             win_lamp,
    output logic             lose_lamp
);
    sum_class_t       cls;
    qual_in_t         qin;
    uword_t           word;
    addr_t            state_q;
    logic [SUM_W-1:0] point_q;
    logic             match;

    dice_sum_decode #(.SUM_W(SUM_W)) u_dec (
        .sum (dice_sum),
        .cls (cls)
    );

    dice_point_unit #(.SUM_W(SUM_W)) u_point (
        .clk   (clk),
        .rst   (rst),
        .load  (word.capture),
        .sum   (dice_sum),
        .point (point_q),
        .match (match)
    );

    always_comb begin
        qin.btn   = roll_btn;
        qin.clr   = clear_btn;
        qin.match = match;
        qin.cls   = cls;
    end

    dice_useq u_seq (
        .clk  (clk),
        .rst  (rst),
        .qin  (qin),
        .addr (state_q),
        .word (word)
    );

    assign roll_en   = word.roll;
    assign win_lamp  = word.win;
    assign lose_lamp = word.lose;
endmodule

// File: rtl/dice_microseq_chk.sv
module dice_microseq_chk #(
    parameter int SUM_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             roll_btn,
    input logic             clear_btn,
    input logic [SUM_W-1:0] dice_sum,
    input logic             roll_en,
    input logic             win_lamp,
    input logic             lose_lamp,
    input logic [3:0]       state_q,
    input logic [SUM_W-1:0] point_q
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (state_q == 4'd0 && !roll_en && !win_lamp && !lose_lamp)); // R1
    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst) $onehot0({roll_en, win_lamp, lose_lamp})); // R9
    AST_WIN_HELD: assert property (@(posedge clk) disable iff (rst) (win_lamp && !clear_btn) |=> win_lamp); // R8
    AST_LOSE_HELD: assert property (@(posedge clk) disable iff (rst) (lose_lamp && !clear_btn) |=> lose_lamp); // R8
    AST_POINT_KEPT: assert property (@(posedge clk) disable iff (rst) (state_q != 4'd4) |=> $stable(point_q)); // R10
    AST_ROLL_HELD: assert property (@(posedge clk) disable iff (rst) (roll_en && roll_btn) |=> roll_en); // R2
    AST_SUM_RANGE: assert property (@(posedge clk) disable iff (rst) (dice_sum <= SUM_W'(12)) || !roll_en || roll_btn || clear_btn); // R2
endmodule

bind dice_microseq dice_microseq_chk #(.SUM_W(SUM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .roll_btn  (roll_btn),
    .clear_btn (clear_btn),
    .dice_sum  (dice_sum),
    .roll_en   (roll_en),
    .win_lamp  (win_lamp),
    .lose_lamp (lose_lamp),
    .state_q   (state_q),
    .point_q   (point_q)
);

// File: tb/test_dice_microseq.sv
module test_dice_microseq;
    localparam int CLK_PERIOD = 10;
    localparam int SUM_W      = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             roll_btn = 1'b0;
    logic             clear_btn = 1'b0;
    logic [SUM_W-1:0] dice_sum = SUM_W'(2);
    logic             roll_en, win_lamp, lose_lamp;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dice_microseq #(.SUM_W(SUM_W)) i_dice_microseq (
        .clk       (clk),
        .rst       (rst),
        .roll_btn  (roll_btn),
        .clear_btn (clear_btn),
        .dice_sum  (dice_sum),
        .roll_en   (roll_en),
        .win_lamp  (win_lamp),
        .lose_lamp (lose_lamp)
    );

    // Behavioural reference: game phases, timed from the requirements.
    int ph = 0;
    int mpoint = 0;

    always @(posedge clk) begin
        int s;
        s = int'(dice_sum);
        if (rst) ph <= 0;
        else begin
            case (ph)
                0:  ph <= roll_btn ? 1 : 0;
                1:  ph <= roll_btn ? 1 : 2;
                2:  ph <= (s == 7 || s == 11) ? 11 : 3;
                3:  ph <= (s == 2 || s == 3 || s == 12) ? 9 : 4;
                4:  begin ph <= 5; mpoint <= s; end
                5:  ph <= roll_btn ? 6 : 5;
                6:  ph <= roll_btn ? 6 : 7;
                7:  ph <= (s == mpoint) ? 11 : 8;
                8:  ph <= (s == 7) ? 9 : 5;
                9:  ph <= clear_btn ? 10 : 9;
                10: ph <= 0;
                11: ph <= clear_btn ? 0 : 11;
                default: ph <= 0;
            endcase
        end
    end

    function automatic string tag_of(int p);
        case (p)
            0: return "R1";
            1, 6: return "R2";
            11: return "R3";
            9, 10: return "R4";
            4, 5: return "R5";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        logic er, ew, el;
        #(CLK_PERIOD/4);
        if (!done) begin
            er = (ph == 1 || ph == 6);
            ew = (ph == 11);
            el = (ph == 9);
            checks++;
            if ({roll_en, win_lamp, lose_lamp} !== {er, ew, el}) begin
                fails++;
                $display("FAIL %s cycle compare: got roll/win/lose=%b%b%b expected %b%b%b",
                         tag_of(ph), roll_en, win_lamp, lose_lamp, er, ew, el);
            end
            checks++;
            if ((32'(roll_en) + 32'(win_lamp) + 32'(lose_lamp)) > 1) begin
                fails++;
                $display("FAIL R9 outputs not exclusive: got %b%b%b expected at most one high",
                         roll_en, win_lamp, lose_lamp);
            end
        end
    end

    task automatic check_out(input logic ew, input logic el, input logic er, input string tag);
        checks++;
        if ({win_lamp, lose_lamp, roll_en} !== {ew, el, er}) begin
            fails++;
            $display("FAIL %s: got win/lose/roll=%b%b%b expected %b%b%b",
                     tag, win_lamp, lose_lamp, roll_en, ew, el, er);
        end
    endtask

    task automatic roll(input int s);
        @(negedge clk);
        roll_btn = 1'b1;
        dice_sum = SUM_W'(3);
        @(negedge clk);
        check_out(1'b0, 1'b0, 1'b1, "R2 roll enabled while held");
        @(negedge clk);
        dice_sum = SUM_W'(s);
        roll_btn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_game();
        clear_btn = 1'b1;
        @(negedge clk);
        clear_btn = 1'b0;
        repeat (2) @(negedge clk);
        check_out(1'b0, 1'b0, 1'b0, "R8 cleared to idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out(1'b0, 1'b0, 1'b0, "R1 outputs low in reset");
        rst = 1'b0;
        @(negedge clk);
        check_out(1'b0, 1'b0, 1'b0, "R1 idle after reset");

        clear_btn = 1'b1;
        repeat (2) @(negedge clk);
        clear_btn = 1'b0;
        @(negedge clk);
        check_out(1'b0, 1'b0, 1'b0, "R8 clear ignored in idle");

        roll(7);  check_out(1'b1, 1'b0, 1'b0, "R3 first 7 wins");
        repeat (3) @(negedge clk);
        check_out(1'b1, 1'b0, 1'b0, "R8 win held");
        clear_game();
        roll(11); check_out(1'b1, 1'b0, 1'b0, "R3 first 11 wins");
        clear_game();
        roll(2);  check_out(1'b0, 1'b1, 1'b0, "R4 first 2 loses");
        repeat (3) @(negedge clk);
        check_out(1'b0, 1'b1, 1'b0, "R8 lose held");
        clear_game();
        roll(4);  check_out(1'b0, 1'b0, 1'b0, "R5 point 4 stored");
        clear_btn = 1'b1;
        @(negedge clk);
        clear_btn = 1'b0;
        @(negedge clk);
        check_out(1'b0, 1'b0, 1'b0, "R8 clear ignored while waiting");
        roll(7);  check_out(1'b0, 1'b1, 1'b0, "R7 later 7 loses");
        clear_game();
        roll(5);  check_out(1'b0, 1'b0, 1'b0, "R5 point 5 stored");
        roll(6);  check_out(1'b0, 1'b0, 1'b0, "R7 later 6 rolls again");
        roll(7);  check_out(1'b0, 1'b1, 1'b0, "R7 later 7 loses");
        clear_game();
        roll(6);  check_out(1'b0, 1'b0, 1'b0, "R5 point 6 stored");
        roll(8);  check_out(1'b0, 1'b0, 1'b0, "R10 point kept after 8");
        roll(9);  check_out(1'b0, 1'b0, 1'b0, "R10 point kept after 9");
        roll(6);  check_out(1'b1, 1'b0, 1'b0, "R6 later match wins");
        clear_game();
        roll(12); check_out(1'b0, 1'b1, 1'b0, "R4 first 12 loses");
        clear_game();
        roll(3);  check_out(1'b0, 1'b1, 1'b0, "R4 first 3 loses");
        clear_game();
        roll(10); check_out(1'b0, 1'b0, 1'b0, "R5 point 10 stored");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_out(1'b0, 1'b0, 1'b0, "R1 reset mid game");
        roll(10); check_out(1'b0, 1'b0, 1'b0, "R1 reset restarts as first roll");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion expected end of sequence");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule